// File: doc/BRIEF.md
# Buffered 16-bit Timer Compare Unit

This block holds a free-running 16-bit up counter and two compare channels, A and B. Each channel's compare value is written over an 8-bit register port in two byte writes. A staging latch holds the low byte until the high byte arrives, so the 16-bit value changes in a single step. Channel A also sets the counter period: its match clears the counter.

An optional double buffer sits in front of each active compare register. When the buffer is enabled and the timer is running, a new value waits in the buffer and moves into the active register only on that channel's next compare match. This lets software retime a waveform without cutting a period short. When the timer is stopped, or the buffer is disabled, a write takes effect at once.

A two-state controller (HALT, COUNT) follows the `run` input one edge later. The counter advances only in COUNT. It moves from HALT to COUNT on the transition *start* (`run` high) and from COUNT to HALT on the transition *stop* (`run` low). Each channel raises a match pulse in every counting cycle where the counter equals its active value.

Top module: `cmp_timer16`

## Requirements
- R1: After reset the counter, both active registers, both buffers and both staging latches are 0. All four read addresses return 0 and neither match output is high.
- R2: A write to a channel's low-byte address (addr[0]=0, addr[1] selects the channel: 0 is A, 1 is B) only updates that channel's staging latch. Neither the readable value nor the active compare value changes.
- R3: A write to a channel's high-byte address (addr[0]=1) commits {written byte, staged low byte} as one 16-bit value in a single clock edge. The other channel is not touched.
- R4: With `dbuf_en`=1 in state COUNT, a committed value goes into the buffer only. The active value keeps its old contents, and the next match happens at the old value.
- R5: With `dbuf_en`=1 in state COUNT, a match pulses that channel's output and loads the buffer into the active register at the same edge. The following period uses the new value.
- R6: With `dbuf_en`=1, reads return the buffer contents (the last value written). With `dbuf_en`=0, reads return the active value.
- R7: With `dbuf_en`=1 in state HALT, a committed value loads both the buffer and the active register at once.
- R8: With `dbuf_en`=0, a committed value loads the active register at once, in HALT and in COUNT alike.
- R9: If an immediate load puts a compare value below the current count, the match is missed until the counter wraps through 0 and climbs back to that value. The block does not correct this.
- R10: A channel A match clears the counter to 0 at the next edge. Otherwise the counter wraps from 0xFFFF to 0, so a channel A value P gives a period of P+1 cycles.
- R11: A match output is high only in state COUNT, in the cycle the counter equals that channel's active value. In HALT both outputs stay low.
- R12: The controller enters COUNT one edge after `run` goes high and HALT one edge after it goes low. In HALT the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | 1 starts counting, 0 stops it |
| dbuf_en | input | 1 | 1 enables the double buffer, 0 bypasses it |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: bit 1 channel (0 A, 1 B), bit 0 byte (0 low, 1 high) |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for `addr`, combinational |
| count | output | 16 | Current counter value |
| match_a | output | 1 | Channel A match pulse |
| match_b | output | 1 | Channel B match pulse |

## Verification
The assertions assume that `run`, `dbuf_en`, `wr_en`, `addr` and `wr_data` change only between clock edges and are held steady through each edge. The transfer and hold properties read `run` from the previous edge, because the controller lags the input by one cycle. The bench drives every input just after a falling edge and samples just after the next falling edge. It always writes the low byte before the high byte, and it leaves at least one cycle of margin between a commit and a match whenever a check depends on their order.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    typedef enum logic {
        TMR_HALT  = 1'b0,
        TMR_COUNT = 1'b1
    } tmr_state_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/cmp_tmr_ctrl.sv
module cmp_tmr_ctrl
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             period_hit,
    output logic             running,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    tmr_state_e state_q, state_d;

    // next-state: start on run, stop on !run
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_HALT:  if (run)  state_d = TMR_COUNT;
            TMR_COUNT: if (!run) state_d = TMR_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_HALT;
        else        state_q <= state_d;
    end

    // outputs: counter advances only while counting
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (state_q == TMR_COUNT)
            count <= period_hit ? '0 : count + STEP;
    end

    assign running = (state_q == TMR_COUNT);

endmodule

// File: rtl/cmp_channel.sv
module cmp_channel #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              dbuf_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  count,
    output logic              match,
    output logic [CNT_W-1:0]  active_q,
    output logic [CNT_W-1:0]  shadow_q,
    output logic [CNT_W-1:0]  view
);

    logic [BYTE_W-1:0] stage_q;
    logic [CNT_W-1:0]  commit_val;
    logic              deferred;

    assign commit_val = {wr_data, stage_q};
    assign deferred   = dbuf_en && running;
    assign match      = running && (count == active_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q  <= '0;
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_lo)
                stage_q <= wr_data;
            if (deferred && match)
                active_q <= shadow_q;
            if (wr_hi) begin
                shadow_q <= commit_val;
                if (!deferred)
                    active_q <= commit_val;
            end
        end
    end

    assign view = dbuf_en ? shadow_q : active_q;

endmodule

// File: rtl/cmp_timer16.sv
module cmp_timer16
    import cmp_timer_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              dbuf_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              match_a,
    output logic              match_b
);

    logic                           running;
    logic [NUM_CH-1:0]              hit;
    logic [NUM_CH-1:0][CNT_W-1:0]   act_v;
    logic [NUM_CH-1:0][CNT_W-1:0]   shd_v;
    logic [NUM_CH-1:0][CNT_W-1:0]   view_v;
    logic [CNT_W-1:0]               sel_view;

    cmp_tmr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .period_hit (hit[0]),
        .running    (running),
        .count      (count)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cmp_channel #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .running  (running),
            .dbuf_en  (dbuf_en),
            .wr_lo    (wr_en && (addr[1] == 1'(g)) && !addr[0]),
            .wr_hi    (wr_en && (addr[1] == 1'(g)) &&  addr[0]),
            .wr_data  (wr_data),
            .count    (count),
            .match    (hit[g]),
            .active_q (act_v[g]),
            .shadow_q (shd_v[g]),
            .view     (view_v[g])
        );
    end

    assign sel_view = view_v[addr[1]];
    assign rd_data  = addr[0] ? sel_view[CNT_W-1:BYTE_W] : sel_view[BYTE_W-1:0];
    assign match_a  = hit[0];
    assign match_b  = hit[1];

endmodule

// File: rtl/cmp_timer16_chk.sv
module cmp_timer16_chk #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              dbuf_en,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [CNT_W-1:0]  count,
    input logic              match_a,
    input logic              match_b,
    input logic              running,
    input logic [CNT_W-1:0]  act_a,
    input logic [CNT_W-1:0]  shd_a
);

    assert_low_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'b00 && !match_a) |=> ($stable(act_a) && $stable(shd_a)));

    assert_dbuf_hide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dbuf_en && wr_en && addr == 2'b01 && !match_a) |=> $stable(act_a));

    assert_dbuf_transfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dbuf_en && match_a && !(wr_en && addr == 2'b01)) |=> (act_a == $past(shd_a)));

    assert_direct_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbuf_en && wr_en && addr == 2'b01) |=> (act_a[CNT_W-1:BYTE_W] == $past(wr_data)));

    assert_period_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        match_a |=> (count == '0));

    assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run) |-> (!match_a && !match_b));

    assert_hold_halt_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |=> $stable(count));

endmodule

bind cmp_timer16 cmp_timer16_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .dbuf_en (dbuf_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .count   (count),
    .match_a (match_a),
    .match_b (match_b),
    .running (running),
    .act_a   (act_v[0]),
    .shd_a   (shd_v[0])
);

// File: tb/cmp_timer16_test.sv
module cmp_timer16_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        dbuf_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'b00;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic [15:0] count;
    logic        match_a;
    logic        match_b;

    int total = 0;
    int bad = 0;

    logic [7:0]  rv;
    logic [15:0] cnt_at;
    logic [15:0] c0;
    logic [15:0] target;
    int          cyc;
    logic        wrapped;

    cmp_timer16 uut (
        .clk(clk), .rst_n(rst_n), .run(run), .dbuf_en(dbuf_en),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .count(count), .match_a(match_a), .match_b(match_b)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr16(input logic ch, input logic [15:0] v);
        wr({ch, 1'b0}, v[7:0]);
        wr({ch, 1'b1}, v[15:8]);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    // wait for a channel A pulse; skip=1 first moves past the current cycle
    task automatic wait_a(input bit skip, output logic [15:0] c, output int n);
        n = 0;
        if (skip) begin @(negedge clk); n++; end
        while (!match_a && n < 100000) begin @(negedge clk); n++; end
        c = count;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 count", 32'(count), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), rv);
            check("R1 read", 32'(rv), 0);
        end
        // R11 count equals active (both 0) but halted: no pulse
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R11 halt no match", {match_a, match_b}, 0);
        end

        // R2 low byte stays in staging latch
        wr(2'b00, 8'h34);
        rd(2'b00, rv); check("R2 active lo", 32'(rv), 0);
        dbuf_en = 1'b1;
        rd(2'b00, rv); check("R2 buffer lo", 32'(rv), 0);
        dbuf_en = 1'b0;
        // R3 high write commits both bytes, other channel untouched
        wr(2'b01, 8'h12);
        rd(2'b00, rv); check("R3 lo", 32'(rv), 32'h34);
        rd(2'b01, rv); check("R3 hi", 32'(rv), 32'h12);
        rd(2'b10, rv); check("R3 chan B lo", 32'(rv), 0);
        rd(2'b11, rv); check("R3 chan B hi", 32'(rv), 0);

        // R7 enabled while halted: both loaded
        dbuf_en = 1'b1;
        wr16(1'b0, 16'd4);
        rd(2'b00, rv); check("R7 buffer", 32'(rv), 4);
        dbuf_en = 1'b0;
        rd(2'b00, rv); check("R7 active", 32'(rv), 4);
        rd(2'b01, rv); check("R7 active hi", 32'(rv), 0);
        dbuf_en = 1'b1;

        // R4/R5/R10 sweep: each new period arrives through the buffer
        @(negedge clk); run = 1'b1;
        for (int p = 5; p <= 30; p++) begin
            wr16(1'b0, 16'(p));
            wait_a(1'b0, cnt_at, cyc);
            check("R4 old value still active", 32'(cnt_at), 32'(p - 1));
            wait_a(1'b1, cnt_at, cyc);
            check("R5 new value after transfer", 32'(cnt_at), 32'(p));
            check("R10 period", 32'(cyc), 32'(p + 1));
        end
        @(negedge clk);
        check("R10 cleared after match", 32'(count), 0);

        // R6 read source depends on mode
        wr16(1'b0, 16'd40);
        rd(2'b00, rv); check("R6 buffer read", 32'(rv), 40);
        run = 1'b0;
        repeat (2) @(negedge clk);
        dbuf_en = 1'b0;
        rd(2'b00, rv); check("R6 active read", 32'(rv), 30);
        // R12 halt holds counter; R11 no pulses
        c0 = count;
        repeat (5) @(negedge clk);
        check("R12 hold", 32'(count), 32'(c0));
        check("R11 halted quiet", {match_a, match_b}, 0);

        // R8 disabled: immediate while halted and while running
        wr16(1'b0, 16'd200);
        rd(2'b00, rv); check("R8 halted load", 32'(rv), 200);
        run = 1'b1;
        c0 = count;
        target = c0 + 16'd20;
        wr16(1'b0, target);
        wait_a(1'b0, cnt_at, cyc);
        check("R8 running load", 32'(cnt_at), 32'(target));

        // R9 below-count load waits for wrap (A period = 0x10000)
        wr16(1'b0, 16'hFFFF);
        while (count < 16'd200) @(negedge clk);
        wr16(1'b1, 16'd50);
        wrapped = 1'b0;
        cyc = 0;
        while (!match_b && cyc < 70000) begin
            @(negedge clk);
            cyc++;
            if (count == 16'd0) wrapped = 1'b1;
        end
        check("R9 wrapped first", 32'(wrapped), 1);
        check("R9 match at value", 32'(count), 50);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule